// File: doc/BRIEF.md
# Software-Armed Watchdog Timer

This block is a watchdog that software switches on and keeps alive by rewriting an 8-bit control register. Bit 7 of the register arms the watchdog. Bits 6..0 hold a 7-bit down-counter. A prescaler runs freely from system reset and divides the clock by `PRESCALE_DIV`. While the watchdog is armed, each prescaler period takes one step off the counter. When bit 6 of the counter reads zero with the watchdog armed, the block raises its reset-request output for a fixed number of clocks.

After power-up the watchdog is disarmed, and it stays disarmed until a write sets bit 7. From then on only a reset can disarm it: either the system reset or the block's own reset request. Software writes any value with bit 6 set to restart the countdown. A write never touches the prescaler. Because of this, the time from a refresh to the next step can be anything from one clock up to a full prescaler period. Software must size its refresh value with one period of margin.

When the reset request fires, the block returns its register to the disarmed default. It then ignores writes until the pulse ends.

Top module: `wdg_timer`

## Requirements
- R1: After system reset the register reads 0x7F (bit 7 clear, counter all ones) and `wdg_rst_o` is low.
- R2: While disarmed the counter never steps and no reset request is made. A write with bit 7 clear loads bits 6..0 into the counter and leaves the watchdog disarmed, even when bit 6 is clear.
- R3: A write with bit 7 set arms the watchdog and loads bits 6..0 into the counter. A read returns the arm state in bit 7 and the counter in bits 6..0.
- R4: While armed, the counter steps down by one on every clock edge where the prescaler finishes a period. The prescaler counts `PRESCALE_DIV` clocks, starts at zero on system reset, and is not restarted by register writes.
- R5: `wdg_rst_o` rises on the clock edge after the register first shows bit 7 set and bit 6 clear. This includes a write that loads bit 6 clear into an armed watchdog.
- R6: Each reset request holds `wdg_rst_o` high for exactly `PULSE_LEN` consecutive clocks.
- R7: On the edge where `wdg_rst_o` rises, the register returns to 0x7F. Writes made while `wdg_rst_o` is high have no effect.
- R8: A refresh written on the edge just before a prescaler period ends is stepped on the very next edge. Refreshing with 0xC0 in that phase raises `wdg_rst_o` two edges after the write.
- R9: When a write and the end of a prescaler period fall on the same edge, the written value is loaded and that step is dropped.
- R10: A write with bit 7 clear does not disarm an armed watchdog.
- R11: Rewriting a value with bit 6 set before bit 6 clears keeps `wdg_rst_o` low indefinitely.
- R12: System reset in the middle of an armed countdown returns the register to 0x7F, restarts the prescaler and cancels the pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_data | input | 8 | Write data: bit 7 arms, bits 6..0 load the counter |
| rd_data | output | 8 | Current register: bit 7 armed, bits 6..0 counter |
| wdg_rst_o | output | 1 | Reset request pulse, `PULSE_LEN` clocks long |

## Verification
The bench places refreshes at chosen prescaler phases and measures the clocks from the write edge to the reset request.

It covers three phases:
- A write on the last edge before a step must give the two-clock minimum. A design that reloads the prescaler on a write would stretch this to a full period.
- A write on the step edge itself must drop that step. A design that lets the step win would read back one less and fire a period early.
- A write just after a step must give three full periods.

It also covers the cases that disarm or keep the watchdog alive:
- A disarm attempt through bit 7 must fail. A design that honours it would never fire.
- A write that loads bit 6 clear into an armed watchdog must fire one clock later.
- Writes during the pulse must be lost. A design that kept them would read back a non-default value after the pulse.
- A system reset mid-count must cancel the pending request, so no pulse follows.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int REG_W     = 8;
    localparam int CNT_W     = 7;
    localparam int ARM_POS   = 7;
    localparam int ALARM_POS = 6;

    localparam logic [CNT_W-1:0] CNT_DEFAULT = {CNT_W{1'b1}};

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] count;
    } wdg_state_t;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_LOAD,
        UPD_STEP,
        UPD_CLEAR
    } wdg_upd_e;

    function automatic wdg_state_t state_default();
        wdg_state_t s;
        s.armed = 1'b0;
        s.count = CNT_DEFAULT;
        return s;
    endfunction

    function automatic logic [REG_W-1:0] to_reg(wdg_state_t s);
        return {s.armed, s.count};
    endfunction

    function automatic logic alarm_of(wdg_state_t s);
        return s.armed && !s.count[ALARM_POS];
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int DIV = 16000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Free-running: only the system reset restarts the phase.
    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             blocked,
    output wdg_state_t       state,
    output logic             fire
);
    wdg_state_t state_q;
    wdg_state_t state_d;
    wdg_upd_e   upd;

    assign fire = alarm_of(state_q);

    // Priority: fire clears, then a write loads, then a prescaler step.
    always_comb begin
        if (fire)
            upd = UPD_CLEAR;
        else if (wr_en && !blocked)
            upd = UPD_LOAD;
        else if (tick && state_q.armed)
            upd = UPD_STEP;
        else
            upd = UPD_HOLD;
    end

    always_comb begin
        state_d = state_q;
        unique case (upd)
            UPD_CLEAR: state_d = state_default();
            UPD_LOAD: begin
                state_d.armed = state_q.armed | wr_data[ARM_POS];
                state_d.count = wr_data[CNT_W-1:0];
            end
            UPD_STEP:  state_d.count = state_q.count - 1'b1;
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= state_default();
        else
            state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int LW = $clog2(LEN + 1);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (start)
            left_q <= LW'(LEN);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int PRESCALE_DIV = 16000,
    parameter int PULSE_LEN    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       wdg_rst_o
);
    logic       tick;
    logic       fire;
    wdg_state_t state;

    wdg_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    wdg_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .blocked (wdg_rst_o),
        .state   (state),
        .fire    (fire)
    );

    wdg_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .busy  (wdg_rst_o)
    );

    assign rd_data = to_reg(state);

endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk #(
    parameter int PULSE_LEN = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       wdg_rst_o
);
    localparam int HW = $clog2(PULSE_LEN + 1) + 1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= '0;
        else if (wdg_rst_o)
            hi_cnt <= hi_cnt + 1'b1;
        else
            hi_cnt <= '0;
    end

    p_pulse_max_r6: assert property (@(posedge clk) disable iff (rst)
        wdg_rst_o |-> hi_cnt < HW'(PULSE_LEN));

    p_pulse_full_r6: assert property (@(posedge clk) disable iff (rst)
        (!wdg_rst_o && hi_cnt != '0) |-> hi_cnt == HW'(PULSE_LEN));

    p_fire_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_data[7] && !rd_data[6]) |=> wdg_rst_o);

    p_default_in_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        wdg_rst_o |-> rd_data == 8'h7F);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[7] && !wr_en) |=> $stable(rd_data));

    p_keep_armed_r10: assert property (@(posedge clk) disable iff (rst)
        rd_data[7] |=> (rd_data[7] || wdg_rst_o));

    p_write_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdg_rst_o && !(rd_data[7] && !rd_data[6]))
        |=> (rd_data[6:0] == $past(wr_data[6:0]))
            && (rd_data[7] == ($past(rd_data[7]) | $past(wr_data[7]))));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_data[7] && rd_data[6] && !wr_en)
        |=> rd_data[7]
            && ((rd_data[6:0] == $past(rd_data[6:0]))
                || (rd_data[6:0] == $past(rd_data[6:0]) - 7'd1)));

endmodule

bind wdg_timer wdg_timer_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .wdg_rst_o (wdg_rst_o)
);

// File: tb/tb_wdg_timer.sv
module tb_wdg_timer;

    localparam int DIV   = 20;
    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wdg_rst_o;

    int checks = 0;
    int errors = 0;
    int edges  = 0;

    always #2 clk = ~clk;

    wdg_timer #(.PRESCALE_DIV(DIV), .PULSE_LEN(PULSE)) dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wdg_rst_o (wdg_rst_o)
    );

    // Edges since system reset release; a step happens on edge index n with n % DIV == 0.
    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic sys_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Wait at negedges until the next edge has index with (index % DIV) == p.
    task automatic align(input int p);
        while (((edges + 1) % DIV) != p) @(negedge clk);
    endtask

    task automatic write_at(input int p, input logic [7:0] d);
        align(p);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int m, input int limit);
        m = 0;
        while (!wdg_rst_o && m < limit) begin
            @(negedge clk);
            m++;
        end
    endtask

    task automatic pulse_width(output int n);
        n = 0;
        while (wdg_rst_o && n < 4 * PULSE) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset_state();
        sys_reset();
        @(negedge clk);
        chk(rd_data == 8'h7F, "R1 reg", rd_data, 8'h7F);
        chk(wdg_rst_o == 1'b0, "R1 out", wdg_rst_o, 0);
    endtask

    task automatic t_disarmed();
        bit seen = 0;
        repeat (3 * DIV) begin @(negedge clk); seen |= wdg_rst_o; end
        chk(rd_data == 8'h7F, "R2 no step", rd_data, 8'h7F);
        write_at(3, 8'h05);
        chk(rd_data == 8'h05, "R2 load disarmed", rd_data, 8'h05);
        repeat (3 * DIV) begin @(negedge clk); seen |= wdg_rst_o; end
        chk(rd_data == 8'h05 && !seen, "R2 idle", {seen, rd_data}, 8'h05);
    endtask

    task automatic t_full_periods();
        int m, n;
        write_at(1, 8'hC2);
        chk(rd_data == 8'hC2, "R3 arm load", rd_data, 8'hC2);
        repeat (DIV - 1) @(negedge clk);
        chk(rd_data == 8'hC1, "R4 one step", rd_data, 8'hC1);
        measure(m, 10 * DIV);
        chk(m == 3 * DIV - (DIV - 1), "R5 timeout from phase 1", m + DIV - 1, 3 * DIV);
        chk(rd_data == 8'h7F, "R7 cleared at fire", rd_data, 8'h7F);
        wr_en = 1'b1; wr_data = 8'hC5;
        @(negedge clk);
        wr_en = 1'b0;
        pulse_width(n);
        chk(n == PULSE - 1, "R6 pulse length", n + 1, PULSE);
        chk(rd_data == 8'h7F, "R7 write in pulse ignored", rd_data, 8'h7F);
    endtask

    task automatic t_min_timeout();
        int m, n;
        write_at(DIV - 1, 8'hC0);
        measure(m, 10 * DIV);
        chk(m == 2, "R8 minimum timeout", m, 2);
        pulse_width(n);
    endtask

    task automatic t_same_edge();
        int m, n;
        write_at(0, 8'hC1);
        chk(rd_data == 8'hC1, "R9 write beats step", rd_data, 8'hC1);
        measure(m, 10 * DIV);
        chk(m == 2 * DIV + 1, "R9 timeout", m, 2 * DIV + 1);
        pulse_width(n);
    endtask

    task automatic t_no_disarm();
        int m, n;
        write_at(1, 8'hC5);
        write_at(1, 8'h7F);
        chk(rd_data == 8'hFF, "R10 stays armed", rd_data, 8'hFF);
        measure(m, 70 * DIV);
        chk(m == 64 * DIV, "R10 still times out", m, 64 * DIV);
        pulse_width(n);
    endtask

    task automatic t_direct_fire();
        int m, n;
        write_at(5, 8'hC9);
        write_at(7, 8'h85);
        measure(m, 4 * DIV);
        chk(m == 1, "R5 armed write bit6 clear", m, 1);
        pulse_width(n);
        write_at(7, 8'h85);
        measure(m, 4 * DIV);
        chk(m == 1, "R5 arming write bit6 clear", m, 1);
        pulse_width(n);
    endtask

    task automatic t_refresh();
        bit seen = 0;
        write_at(1, 8'hC1);
        for (int i = 0; i < 12; i++) begin
            while (((edges + 1) % DIV) != 1) begin
                seen |= wdg_rst_o;
                @(negedge clk);
            end
            wr_en = 1'b1; wr_data = 8'hC1;
            @(negedge clk);
            wr_en = 1'b0;
            seen |= wdg_rst_o;
        end
        chk(!seen, "R11 kept alive", seen, 0);
        chk(rd_data == 8'hC1, "R11 reg", rd_data, 8'hC1);
    endtask

    task automatic t_sys_reset_mid();
        bit seen = 0;
        write_at(1, 8'hC2);
        sys_reset();
        @(negedge clk);
        chk(rd_data == 8'h7F, "R12 reg cleared", rd_data, 8'h7F);
        repeat (5 * DIV) begin @(negedge clk); seen |= wdg_rst_o; end
        chk(!seen, "R12 request cancelled", seen, 0);
        write_at(1, 8'hC1);
        repeat (DIV - 1) @(negedge clk);
        chk(rd_data == 8'hC0, "R12 prescaler restarted", rd_data, 8'hC0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_disarmed();
        t_full_periods();
        t_min_timeout();
        t_same_edge();
        t_no_disarm();
        t_direct_fire();
        t_refresh();
        t_sys_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule